// File: doc/BRIEF.md
# Dual-Compare 8-Bit Waveform Timer

The block is an 8-bit up-counter that advances only on a detected edge of a clock source chosen by software. The source is either one of several taps of a free-running internal divider or an external pin, and the active edge is either rising or falling. Edge detection works on levels only. The block keeps the selected level, after the polarity has been applied, from the previous cycle and compares it with the current one. A change of the source selection or of the polarity is therefore treated like any other level change. When the selected level moves in the active direction because of such a change, the counter advances once.

Two compare channels, A and B, check the counter value that results from each increment. Each channel has its own 2-bit action that it applies to one waveform output. When both channels match on the same increment, one action is applied, picked by a fixed priority. Each channel keeps a sticky match flag, and there is a sticky flag for wrap-around. Channel A can also restart the counter at zero. Software reaches the block through a single-cycle write port: an address, a data byte and a strobe. The counter and the flags are visible directly on output ports.

Top module: `dcmp_timer8`

## Requirements
- R1: While reset is asserted, and on its release, count_o is 0, the three flags are 0 and wave_out is 0.
- R2: The counter advances by one only on a detected active edge of the selected source. The external pin passes through two synchronizer flops, so a transition on it moves count_o on the third rising clock edge after the transition.
- R3: Control bit 3 (address 0) selects the active edge: 0 counts rising edges, 1 counts falling edges. Transitions in the other direction leave the counter unchanged.
- R4: A write to the control register can change the source or the polarity. If the level seen by the detector then moves in the active direction, the counter advances exactly once. If it moves in the other direction, the counter does not change.
- R5: The write map is: address 0 is control (bits 1:0 select the divider tap, bit 2 selects the external pin, bit 3 sets the polarity, bit 4 enables clear-on-A); address 1 holds the actions (bits 1:0 for A, bits 3:2 for B); addresses 2 and 3 hold compare values A and B; address 4 loads the counter; address 5 clears flags. A counter load shows on count_o after one clock.
- R6: A compare match is tested on the value after the increment. A match sets a sticky flag (match_a_o, match_b_o). Writing 1 to bit 0 (A) or bit 1 (B) at address 5 clears that flag; writing 0 leaves it set.
- R7: Action codes are 00 no change, 01 drive low, 10 drive high and 11 toggle. The action takes effect on wave_out in the same clock as the counter update.
- R8: When A and B match on the same increment, one action is applied: toggle, then drive-high, then drive-low, then no change, in falling order of priority.
- R9: With clear-on-A set, a match on A loads 0 into the counter instead of the matching value, and the A flag is still set.
- R10: A wrap from 255 to 0 sets ovf_o. Writing 1 to bit 2 at address 5 clears it.
- R11: With the internal source selected, the select value k picks divider bit 2k, and the divider advances every clock. Select 0 with rising edges gives one count every 2 clocks. Select 1 gives one count every 8 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| ext_clk_in | input | 1 | External count source, asynchronous |
| wave_out | output | 1 | Waveform output driven by the compare actions |
| count_o | output | 8 | Current counter value |
| match_a_o | output | 1 | Sticky compare A match flag |
| match_b_o | output | 1 | Sticky compare B match flag |
| ovf_o | output | 1 | Sticky wrap-around flag |

## Verification
A match on compare A and a match on compare B can fall on the same increment. Each then asks for its own action on the single waveform pin. The bench provokes this by loading equal compare values and stepping the counter onto them. It goes through all sixteen pairs of actions, once with the pin held low beforehand and once with it held high. The pin is judged against a bench function that applies the priority order. A second overlap is a wrap to zero that is also a compare hit, with or without clear-on-A. The random phase reaches it, and the overflow and match flags are checked together after every step.

// File: rtl/dcmp_timer8_pkg.sv
package dcmp_timer8_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } out_act_e;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] REG_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] REG_ACT  = 3'd1;
   localparam logic [ADDR_W-1:0] REG_CMP0 = 3'd2;
   localparam logic [ADDR_W-1:0] REG_CNT  = 3'd4;
   localparam logic [ADDR_W-1:0] REG_FLAG = 3'd5;

   // Rank used when several channels request an action in one cycle.
   function automatic int unsigned act_rank(input out_act_e a);
      case (a)
         ACT_TOGGLE: return 3;
         ACT_HIGH:   return 2;
         ACT_LOW:    return 1;
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/dcmp_edge_src.sv
module dcmp_edge_src #(
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned TAP_BASE    = 0,
   parameter int unsigned TAP_STEP    = 2,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             use_ext_i,
   input  logic             fall_i,
   input  logic             ext_i,
   output logic             edge_o
);

   localparam int unsigned NUM_INT = 2 ** SEL_W;

   logic [DIV_W-1:0]       div_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic [NUM_INT-1:0]     int_clk;
   logic                   lvl;
   logic                   adj;
   logic                   adj_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= ext_i;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
         end
      end
   endgenerate

   for (genvar k = 0; k < NUM_INT; k++) begin : g_tap
      assign int_clk[k] = div_q[TAP_BASE + k * TAP_STEP];
   end

   // Polarity folded into the level: any switch shows as a level step.
   assign lvl = use_ext_i ? sync_q[SYNC_STAGES-1] : int_clk[sel_i];
   assign adj = lvl ^ fall_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) adj_q <= 1'b0;
      else        adj_q <= adj;
   end

   assign edge_o = adj & ~adj_q;

endmodule

// File: rtl/dcmp_cmp_chan.sv
module dcmp_cmp_chan import dcmp_timer8_pkg::*; #(
   parameter int unsigned CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] cnt_next_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  out_act_e         act_i,
   input  logic             flag_clr_i,
   output logic             hit_o,
   output out_act_e         act_o,
   output logic             flag_o
);

   assign hit_o = inc_i && (cnt_next_i == cmp_i);
   assign act_o = hit_o ? act_i : ACT_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o <= 1'b0;
      else if (hit_o)      flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
   end

endmodule

// File: rtl/dcmp_out_resolve.sv
module dcmp_out_resolve import dcmp_timer8_pkg::*; #(
   parameter int unsigned NUM_CH = 2
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_CH-1:0][1:0] acts_i,
   output logic                   wave_o
);

   out_act_e win;

   always_comb begin
      win = ACT_NONE;
      for (int i = 0; i < NUM_CH; i++) begin
         if (act_rank(out_act_e'(acts_i[i])) > act_rank(win))
            win = out_act_e'(acts_i[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wave_o <= 1'b0;
      else begin
         case (win)
            ACT_LOW:    wave_o <= 1'b0;
            ACT_HIGH:   wave_o <= 1'b1;
            ACT_TOGGLE: wave_o <= ~wave_o;
            default:    wave_o <= wave_o;
         endcase
      end
   end

endmodule

// File: rtl/dcmp_timer8.sv
module dcmp_timer8 import dcmp_timer8_pkg::*; #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned TAP_BASE    = 0,
   parameter int unsigned TAP_STEP    = 2,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              ext_clk_in,
   output logic              wave_out,
   output logic [CNT_W-1:0]  count_o,
   output logic              match_a_o,
   output logic              match_b_o,
   output logic              ovf_o
);

   localparam int unsigned NUM_CH   = 2;
   localparam int unsigned EXT_BIT  = SEL_W;
   localparam int unsigned FALL_BIT = SEL_W + 1;
   localparam int unsigned CLRA_BIT = SEL_W + 2;
   localparam int unsigned OVF_BIT  = NUM_CH;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < SEL_W + 3 || CNT_W < 2 * NUM_CH) begin : g_bad_cnt_w
         $error("CNT_W too narrow for the control and action fields");
      end
      if (TAP_BASE + (2 ** SEL_W - 1) * TAP_STEP >= DIV_W) begin : g_bad_tap
         $error("divider taps exceed DIV_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0]  sel_q;
   logic              use_ext_q;
   logic              fall_q;
   logic              clr_on_a;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_next;
   logic              ovf_q;
   logic              inc_w;
   logic              edge_w;
   logic              cnt_wr;
   logic              flag_wr;
   logic [NUM_CH-1:0] hit_w;
   logic [NUM_CH-1:0] flag_w;
   logic [NUM_CH-1:0] flag_clr_w;
   logic [NUM_CH-1:0][1:0] act_w;

   assign cnt_wr  = wr_en && (wr_addr == REG_CNT);
   assign flag_wr = wr_en && (wr_addr == REG_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= '0;
         use_ext_q <= 1'b0;
         fall_q    <= 1'b0;
         clr_on_a  <= 1'b0;
      end else if (wr_en && wr_addr == REG_CTRL) begin
         sel_q     <= wr_data[SEL_W-1:0];
         use_ext_q <= wr_data[EXT_BIT];
         fall_q    <= wr_data[FALL_BIT];
         clr_on_a  <= wr_data[CLRA_BIT];
      end
   end

   dcmp_edge_src #(
      .SEL_W       (SEL_W),
      .DIV_W       (DIV_W),
      .TAP_BASE    (TAP_BASE),
      .TAP_STEP    (TAP_STEP),
      .SYNC_STAGES (SYNC_STAGES)
   ) edge_src_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel_q),
      .use_ext_i (use_ext_q),
      .fall_i    (fall_q),
      .ext_i     (ext_clk_in),
      .edge_o    (edge_w)
   );

   // A software load of the counter takes precedence over a count edge.
   assign inc_w    = edge_w && !cnt_wr;
   assign cnt_next = cnt_q + CNT_ONE;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [CNT_W-1:0] cmp_q;
      out_act_e         act_q;
      out_act_e         act_req;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q <= CNT_MAX;
            act_q <= ACT_NONE;
         end else begin
            if (wr_en && wr_addr == REG_CMP0 + ADDR_W'(ch))
               cmp_q <= wr_data;
            if (wr_en && wr_addr == REG_ACT)
               act_q <= out_act_e'(wr_data[2*ch +: 2]);
         end
      end

      assign flag_clr_w[ch] = flag_wr && wr_data[ch];

      dcmp_cmp_chan #(.CNT_W(CNT_W)) cmp_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .inc_i      (inc_w),
         .cnt_next_i (cnt_next),
         .cmp_i      (cmp_q),
         .act_i      (act_q),
         .flag_clr_i (flag_clr_w[ch]),
         .hit_o      (hit_w[ch]),
         .act_o      (act_req),
         .flag_o     (flag_w[ch])
      );

      assign act_w[ch] = act_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (cnt_wr)               cnt_q <= wr_data;
      else if (inc_w) begin
         if (clr_on_a && hit_w[0])   cnt_q <= '0;
         else                        cnt_q <= cnt_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ovf_q <= 1'b0;
      else if (inc_w && cnt_q == CNT_MAX)      ovf_q <= 1'b1;
      else if (flag_wr && wr_data[OVF_BIT])    ovf_q <= 1'b0;
   end

   dcmp_out_resolve #(.NUM_CH(NUM_CH)) resolve_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .acts_i (act_w),
      .wave_o (wave_out)
   );

   assign count_o   = cnt_q;
   assign match_a_o = flag_w[0];
   assign match_b_o = flag_w[1];
   assign ovf_o     = ovf_q;

endmodule

// File: rtl/dcmp_timer8_chk.sv
module dcmp_timer8_chk #(
   parameter int unsigned CNT_W = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             inc,
   input logic             cnt_wr,
   input logic             clr_on_a,
   input logic             hit_a,
   input logic             flag_clr_a,
   input logic [CNT_W-1:0] count_o,
   input logic             wave_out,
   input logic             match_a_o,
   input logic             ovf_o
);

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !cnt_wr) |=> $stable(count_o));

   // R7
   wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(wave_out));

   // R6
   flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a_o && !flag_clr_a) |=> match_a_o);

   // R9
   clr_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && clr_on_a && hit_a && !cnt_wr) |=> (count_o == '0));

   // R10
   ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> ($past(count_o) == {CNT_W{1'b1}} && $past(inc)));

endmodule

bind dcmp_timer8 dcmp_timer8_chk #(.CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .inc        (inc_w),
   .cnt_wr     (cnt_wr),
   .clr_on_a   (clr_on_a),
   .hit_a      (hit_w[0]),
   .flag_clr_a (flag_clr_w[0]),
   .count_o    (count_o),
   .wave_out   (wave_out),
   .match_a_o  (match_a_o),
   .ovf_o      (ovf_o)
);

// File: tb/dcmp_timer8_tb_top.sv
module dcmp_timer8_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       ext_clk_in = 1'b0;
   logic       wave_out;
   logic [7:0] count_o;
   logic       match_a_o, match_b_o, ovf_o;

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   int m_cnt = 0, m_ca = 255, m_cb = 255, m_aa = 0, m_ab = 0;
   int m_clr = 0, m_wave = 0, m_fa = 0, m_fb = 0, m_ovf = 0;

   always #5 clk = ~clk;

   dcmp_timer8 dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ext_clk_in(ext_clk_in), .wave_out(wave_out),
      .count_o(count_o), .match_a_o(match_a_o), .match_b_o(match_b_o),
      .ovf_o(ovf_o)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pick_act(input int a, input int b);
      if (a == 3 || b == 3) return 3;
      if (a == 2 || b == 2) return 2;
      if (a == 1 || b == 1) return 1;
      return 0;
   endfunction

   task automatic model_inc();
      int nxt, ma, mb, r;
      nxt = (m_cnt + 1) & 255;
      if (m_cnt == 255) m_ovf = 1;
      ma = (nxt == m_ca);
      mb = (nxt == m_cb);
      r = pick_act(ma ? m_aa : 0, mb ? m_ab : 0);
      if (r == 1) m_wave = 0;
      else if (r == 2) m_wave = 1;
      else if (r == 3) m_wave = 1 - m_wave;
      if (ma) m_fa = 1;
      if (mb) m_fb = 1;
      m_cnt = (m_clr != 0 && ma) ? 0 : nxt;
   endtask

   task automatic check_all(input string req);
      check({req, " count"}, int'(count_o), m_cnt);
      check({req, " wave"}, int'(wave_out), m_wave);
      check({req, " flagA"}, int'(match_a_o), m_fa);
      check({req, " flagB"}, int'(match_b_o), m_fb);
      check({req, " ovf"}, int'(ovf_o), m_ovf);
   endtask

   task automatic wr(input logic [2:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   // one rising edge on the external pin, rising mode
   task automatic tick(input string req);
      @(negedge clk);
      ext_clk_in = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check({req, " R2 no count before sync"}, int'(count_o), m_cnt);
      @(posedge clk);
      @(negedge clk);
      model_inc();
      check_all(req);
      ext_clk_in = 1'b0;
      settle();
      check({req, " R3 opposite edge"}, int'(count_o), m_cnt);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      int c1, c2, base;
      void'($urandom(32'd7391));
      repeat (3) @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release wave", int'(wave_out), 0);

      // move to external source, rising edges
      wr(3'd0, 8'h04);
      settle();
      wr(3'd1, 0);
      wr(3'd4, 0);
      wr(3'd5, 7);
      m_cnt = 0; m_fa = 0; m_fb = 0; m_ovf = 0;
      check_all("R5 setup");

      // R5 counter load
      wr(3'd4, 8'h5A);
      m_cnt = 8'h5A;
      check("R5 load", int'(count_o), m_cnt);

      // R2 plain counting
      for (int i = 0; i < 3; i++) tick("R2");

      // R4 polarity switch with level low: counts once
      wr(3'd0, 8'h0C);
      settle();
      model_inc();
      check("R4 spurious on polarity switch", int'(count_o), m_cnt);
      // R3 falling mode: rising edge ignored, falling edge counts
      ext_clk_in = 1'b1;
      settle();
      check("R3 rising ignored in falling mode", int'(count_o), m_cnt);
      ext_clk_in = 1'b0;
      settle();
      model_inc();
      check("R3 falling counted", int'(count_o), m_cnt);
      // R4 back to rising with level low: no count
      wr(3'd0, 8'h04);
      settle();
      check("R4 no count on inactive-direction switch", int'(count_o), m_cnt);

      // R7 actions
      wr(3'd4, 8'h10); m_cnt = 8'h10;
      wr(3'd2, 8'h11); m_ca = 8'h11;
      wr(3'd3, 8'h13); m_cb = 8'h13;
      wr(3'd1, 2 | (1 << 2)); m_aa = 2; m_ab = 1;
      for (int i = 0; i < 3; i++) tick("R7 high/low");
      wr(3'd2, 8'h15); m_ca = 8'h15;
      wr(3'd1, 3); m_aa = 3; m_ab = 0;
      for (int i = 0; i < 3; i++) tick("R7 toggle");

      // R6 flag clears
      wr(3'd5, 0);
      check("R6 write 0 keeps A", int'(match_a_o), 1);
      wr(3'd5, 1); m_fa = 0;
      check("R6 clear A", int'(match_a_o), 0);
      check("R6 B kept", int'(match_b_o), 1);
      wr(3'd5, 2); m_fb = 0;
      check("R6 clear B", int'(match_b_o), 0);

      // R8 simultaneous matches, all pairs, both starting levels
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
               wr(3'd3, 0); m_cb = 0;
               wr(3'd2, 8'h31); m_ca = 8'h31;
               wr(3'd1, (s != 0) ? 2 : 1); m_aa = (s != 0) ? 2 : 1; m_ab = 0;
               wr(3'd4, 8'h30); m_cnt = 8'h30;
               tick("R8 preset");
               wr(3'd3, 8'h31); m_cb = 8'h31;
               wr(3'd1, a | (b << 2)); m_aa = a; m_ab = b;
               wr(3'd4, 8'h30); m_cnt = 8'h30;
               tick("R8 A+B");
            end
         end
      end

      // R9 clear on A
      wr(3'd1, 0); m_aa = 0; m_ab = 0;
      wr(3'd0, 8'h14); m_clr = 1;
      wr(3'd2, 5); m_ca = 5;
      wr(3'd3, 8'h80); m_cb = 8'h80;
      wr(3'd4, 3); m_cnt = 3;
      for (int i = 0; i < 3; i++) tick("R9");
      wr(3'd0, 8'h04); m_clr = 0;

      // R10 wrap
      wr(3'd2, 8'h80); m_ca = 8'h80;
      wr(3'd4, 8'hFE); m_cnt = 8'hFE;
      tick("R10 to 255");
      tick("R10 wrap");
      wr(3'd5, 4); m_ovf = 0;
      check("R10 ovf cleared", int'(ovf_o), 0);

      // random phase
      for (int it = 0; it < 40; it++) begin
         base = int'($urandom % 256);
         m_ca = (base + 1 + int'($urandom % 6)) & 255;
         m_cb = (base + 1 + int'($urandom % 6)) & 255;
         m_aa = int'($urandom % 4);
         m_ab = int'($urandom % 4);
         m_clr = int'($urandom % 2);
         wr(3'd2, m_ca);
         wr(3'd3, m_cb);
         wr(3'd1, m_aa | (m_ab << 2));
         wr(3'd0, 8'h04 | (m_clr << 4));
         wr(3'd4, base); m_cnt = base;
         for (int i = 0; i < 6; i++) tick("R8 random");
      end

      // R11 internal divider taps
      wr(3'd1, 0); m_aa = 0; m_ab = 0;
      wr(3'd0, 8'h00);
      settle();
      c1 = int'(count_o);
      repeat (20) @(posedge clk);
      @(negedge clk);
      c2 = int'(count_o);
      check("R11 select 0 rate", (c2 - c1) & 255, 10);
      wr(3'd0, 8'h01);
      settle();
      c1 = int'(count_o);
      repeat (32) @(posedge clk);
      @(negedge clk);
      c2 = int'(count_o);
      check("R11 select 1 rate", (c2 - c1) & 255, 4);
      check("R11 wave untouched", int'(wave_out), m_wave);

      summary();
      $finish;
   end

endmodule